// File: doc/BRIEF.md
# Binary-Field Almost-Inverse Inverter

This block returns the multiplicative inverse of a nonzero element of GF(2^m), with the element written in polynomial basis. The reduction polynomial is an input and is read when an operation begins, so one instance can serve any irreducible polynomial of degree m. Only shifts, XORs and register swaps are used. A start pulse loads the operand. After a number of cycles that depends on the data, a one-cycle done pulse reports the inverse.

Four registers drive the iteration: a working value Y, a partner D, and two cofactors Z and B. Y begins as the operand, D as the polynomial, Z as 1 and B as 0. When Y is even, Y is divided by x. In the same step Z is divided by x, after P is first folded into Z if Z is odd. When Y is odd and equal to 1, Z is the answer. Otherwise, if D is numerically larger than Y, the pairs (D,Y) and (B,Z) trade places. Then Y takes Y XOR D and Z takes Z XOR B. A zero operand has no inverse. It is flagged at once instead of being iterated.

Top module: `gfInverter`

## Requirements
- R1: After reset, done, err and result are all 0.
- R2: For a start with a nonzero operand A and an irreducible polynomial P of degree m (bit m of poly set), done goes high for exactly one cycle. In that cycle result times A, reduced modulo P, equals 1.
- R3: A start with operand 0 raises done in the cycle right after the start is sampled, with err = 1, and no iteration takes place.
- R4: A completed nonzero operation reports err = 0 in its done cycle.
- R5: Each clock while busy performs one action. If Y is even, Y and Z are both divided by x, with P folded into Z first when Z is odd. Else, if Y equals 1, the result is captured. Otherwise, if D > Y as an unsigned number, D,Y and B,Z are swapped, and then Y ^= D and Z ^= B. Done rises on the clock after the capture decision.
- R6: A start pulse seen while an operation is in progress is ignored.
- R7: result and err keep their values from one done pulse until the next accepted start.
- R8: Operand 1 finishes with result 1, with done high on the second clock after the start is sampled.
- R9: The polynomial is sampled with the start. A change on poly during an operation has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an inversion; sampled only when idle |
| operand | input | M | Element to invert |
| poly | input | M+1 | Reduction polynomial, bit M is the leading term |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set when the accepted operand was zero |
| result | output | M | Inverse of the operand |

## Verification
The assertions assume that poly is irreducible of degree m whenever a start is accepted. Under that assumption every nonzero operand is coprime to P, and the loop bound of about 4m clocks holds. The bench drives only the two irreducible degree-8 polynomials 0x11B and 0x11D, and it sweeps every nonzero operand under each. Reducible polynomials are never presented. The one mid-run change to poly comes after the start has been sampled.

// File: rtl/invPkg.sv
package invPkg;
  // one strobe per datapath action, at most one active per clock
  typedef struct packed {
    logic load;
    logic shift;
    logic step;
    logic capture;
  } invCmd_t;
endpackage

// File: rtl/invDatapath.sv
module invDatapath
  import invPkg::*;
#(
  parameter int M = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  invCmd_t      cmd,
  input  logic [M-1:0] operand,
  input  logic [M:0]   poly,
  output logic         opZero,
  output logic         yOdd,
  output logic         yIsOne,
  output logic [M-1:0] result
);
  localparam int W = M + 1;

  logic [W-1:0] yReg, dReg, polyReg;
  logic [M-1:0] zReg, bReg;
  logic [W-1:0] zFold;
  logic         dAbove;

  assign opZero = (operand == '0);
  assign yOdd   = yReg[0];
  assign yIsOne = (yReg == W'(1));
  assign dAbove = (dReg > yReg);
  // fold P into Z when Z is odd; bit 0 of the sum is then zero
  assign zFold  = zReg[0] ? ({1'b0, zReg} ^ polyReg) : {1'b0, zReg};

  always_ff @(posedge clk) begin
    if (rst) begin
      yReg    <= '0;
      dReg    <= '0;
      polyReg <= '0;
      zReg    <= '0;
      bReg    <= '0;
      result  <= '0;
    end else begin
      if (cmd.load) begin
        yReg    <= {1'b0, operand};
        dReg    <= poly;
        polyReg <= poly;
        zReg    <= M'(1);
        bReg    <= '0;
      end else if (cmd.shift) begin
        yReg <= yReg >> 1;
        zReg <= zFold[M:1];
      end else if (cmd.step) begin
        yReg <= yReg ^ dReg;
        zReg <= zReg ^ bReg;
        if (dAbove) begin
          dReg <= yReg;
          bReg <= zReg;
        end
      end
      if (cmd.capture) result <= zReg;
    end
  end
endmodule

// File: rtl/invControl.sv
module invControl
  import invPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    opZero,
  input  logic    yOdd,
  input  logic    yIsOne,
  output invCmd_t cmd,
  output logic    running,
  output logic    done,
  output logic    err
);
  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;
  ctlState_t state;

  assign running = (state == ST_RUN);

  always_comb begin
    cmd = '0;
    if (state == ST_IDLE) begin
      cmd.load = start && !opZero;
    end else begin
      if (!yOdd)       cmd.shift   = 1'b1;
      else if (yIsOne) cmd.capture = 1'b1;
      else             cmd.step    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (opZero) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            err   <= 1'b0;
            state <= ST_RUN;
          end
        end
        ST_RUN: if (cmd.capture) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gfInverter.sv
module gfInverter
  import invPkg::*;
#(
  parameter int M = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] operand,
  input  logic [M:0]   poly,
  output logic         done,
  output logic         err,
  output logic [M-1:0] result
);
  invCmd_t cmd;
  logic    opZero, yOdd, yIsOne, running;
  logic [3:0] cmdVec;

  assign cmdVec = {cmd.load, cmd.shift, cmd.step, cmd.capture};

  invControl u_ctl (
    .clk(clk), .rst(rst), .start(start), .opZero(opZero),
    .yOdd(yOdd), .yIsOne(yIsOne), .cmd(cmd), .running(running),
    .done(done), .err(err)
  );

  invDatapath #(.M(M)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .operand(operand), .poly(poly),
    .opZero(opZero), .yOdd(yOdd), .yIsOne(yIsOne), .result(result)
  );
endmodule

// File: rtl/gfInverterChk.sv
module gfInverterChk #(
  parameter int M = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [M-1:0] operand,
  input logic         running,
  input logic [3:0]   cmdVec,
  input logic         done,
  input logic         err,
  input logic [M-1:0] result
);
  localparam int BOUND = 4 * M + 4;
  localparam int CW    = $clog2(BOUND + 2) + 1;

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst)          runCnt <= '0;
    else if (running) runCnt <= runCnt + 1'b1;
    else              runCnt <= '0;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (!running && start && operand == '0) |=> (done && err));

  assert_ok_flag_R4: assert property (@(posedge clk) disable iff (rst)
    running |=> (!done || !err));

  assert_one_action_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmdVec));

  assert_bounded_run_R5: assert property (@(posedge clk) disable iff (rst)
    runCnt <= CW'(BOUND));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (running || !start) |=> (done || ($stable(result) && $stable(err))));
endmodule

bind gfInverter gfInverterChk #(.M(M)) u_chk (
  .clk(clk), .rst(rst), .start(start), .operand(operand),
  .running(running), .cmdVec(cmdVec), .done(done), .err(err),
  .result(result)
);

// File: tb/gfInverter_tb.sv
module gfInverter_tb;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [MW-1:0] operand = '0;
  logic [MW:0]   poly = 9'h11B;
  logic          done, err;
  logic [MW-1:0] result;

  int testsRun = 0, testsFailed = 0, cyc = 0;

  // behavioural reference state
  int  mY, mD, mB, mZ, mP, mA;
  bit  mBusy = 0, expDone = 0, expErr = 0;
  int  expRes = 0;

  always #2 clk = ~clk;

  gfInverter #(.M(MW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .operand(operand), .poly(poly),
    .done(done), .err(err), .result(result)
  );

  function automatic int gfMul(int a, int b, int p);
    int r = 0;
    for (int i = 0; i < MW; i++) if (((b >> i) & 1) != 0) r ^= a << i;
    for (int i = 2 * MW - 2; i >= MW; i--)
      if (((r >> i) & 1) != 0) r ^= p << (i - MW);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mBusy = 0; expDone = 0; expErr = 0; expRes = 0;
    end else begin
      expDone = 0;
      if (!mBusy) begin
        if (start) begin
          if (operand == 0) begin
            expDone = 1; expErr = 1;
          end else begin
            mA = operand; mP = poly; mY = operand; mD = poly;
            mB = 0; mZ = 1; expErr = 0; mBusy = 1;
          end
        end
      end else if (mY % 2 == 0) begin
        mY = mY / 2;
        if (mZ % 2 == 1) mZ = mZ ^ mP;
        mZ = mZ / 2;
      end else if (mY == 1) begin
        expDone = 1; expRes = mZ; mBusy = 0;
      end else begin
        int tY, tZ;
        tY = mY; tZ = mZ;
        if (mD > mY) begin
          mY = mD; mD = tY; mZ = mB; mB = tZ;
        end
        mY = mY ^ mD; mZ = mZ ^ mB;
      end
    end
  end

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (!rst) begin
      check(done == expDone, "R5 done timing", done, expDone);
      if (expDone) begin
        check(err == expErr, "R3/R4 err flag", err, expErr);
        if (!expErr) begin
          check(result == expRes[MW-1:0], "R2 result vs model", result, expRes);
          check(gfMul(result, mA, mP) == 1, "R2 product is one",
                gfMul(result, mA, mP), 1);
        end
      end
      if (!done) begin
        check(result == expRes[MW-1:0], "R7 result hold", result, expRes);
        check(err == expErr, "R7 err hold", err, expErr);
      end
    end
  end

  task automatic runOp(input int a, input int p, input bit busyStart, input bit polyKick);
    @(negedge clk);
    operand = a[MW-1:0]; poly = p[MW:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busyStart || polyKick) begin
      @(negedge clk);
      if (busyStart) begin
        operand = 8'h02; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      if (polyKick) poly = 9'h11D;
    end
    while (mBusy) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && err == 0 && result == 0, "R1 reset state",
          {done, err, result}, 0);

    runOp(8'h53, 9'h11B, 0, 0);
    check(result == 8'hCA, "R2 known inverse 53", result, 8'hCA);

    runOp(1, 9'h11B, 0, 0);
    check(result == 8'h01, "R8 unit operand", result, 1);
    // R8 latency: start sampled, load edge, capture edge, then done
    @(negedge clk);
    operand = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 0, "R8 not yet done", done, 0);
    @(negedge clk);
    check(done == 1, "R8 done on second clock", done, 1);

    runOp(0, 9'h11B, 0, 0);
    check(err == 1 && done == 1, "R3 zero operand", {done, err}, 3);
    repeat (3) @(negedge clk);
    check(err == 1, "R7 err held after zero", err, 1);

    runOp(8'h53, 9'h11B, 1, 0);
    check(result == 8'hCA, "R6 start while busy ignored", result, 8'hCA);
    check(err == 0, "R4 err clear", err, 0);

    runOp(8'h53, 9'h11B, 0, 1);
    check(result == 8'hCA, "R9 poly change mid-run", result, 8'hCA);

    for (int a = 1; a < 256; a++) runOp(a, 9'h11B, 0, 0);
    for (int a = 1; a < 256; a++) runOp(a, 9'h11D, 0, 0);
    check(gfMul(result, 8'hFF, 9'h11D) == 1, "R2 last sweep value",
          gfMul(result, 8'hFF, 9'h11D), 1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule